// File: doc/BRIEF.md
# Dual-Edge Readout Request Filter

This block sits between a stave-side link and the front-end chips of one hybrid. Two serial lines arrive, and each carries two streams that share the line by clock edge. On the request line, the bit sampled at the rising edge belongs to the regional readout request stream. The bit sampled at the falling edge belongs to the trigger readout stream. On the command line, the rising-edge bit is a command bit and the falling-edge bit is a trigger bit.

Regional requests are framed by a `101` start pattern. The start pattern is followed by a 14-bit position field, an 8-bit event identifier and a trailer bit that must be 1, for 26 bits in all. A request is forwarded only when its position equals the hybrid's programmed position, or when the position is all ones, which addresses every hybrid. A forwarded request is shortened to 12 bits: start pattern, identifier and trailer. Trigger readout packets are 12 bits long: start pattern, 8-bit identifier and trailer. They are passed through bit for bit after one clock of delay. The two outgoing request streams are merged back onto one dual-edge line, and the command line is regenerated in the same way.

Top module: `dual_edge_req_filter`

## Requirements
- R1: A synchronous active-high reset, seen at both clock edges, drives `req_out`, `cmd_out` and `trailer_err` low. It also leaves both packet receivers hunting for a start pattern, so that line activity during reset never starts a packet.
- R2: A regional request whose 14-bit position equals `own_pos` and whose trailer is 1 is forwarded. The 12-bit packet `{101, id[7:0], 1}` appears MSB first on `req_out` during the high clock phases. The first bit appears in the cycle that follows the rising edge that sampled the trailer.
- R3: A regional request whose position differs from `own_pos` in any bit, and is not all ones, leaves `req_out` low in every high phase.
- R4: A regional request whose position is 14'h3FFF is forwarded whatever the value of `own_pos`.
- R5: A regional request whose trailer bit is 0 produces no output and sets `trailer_err`. The flag then stays set until reset, and later requests are still forwarded.
- R6: During the low clock phases, `req_out` repeats the falling-edge bit of `req_in` from one clock earlier, unchanged.
- R7: A trigger readout packet (`101`, 8-bit id, trailer) whose trailer is 0 sets `trailer_err` from the cycle after the falling edge that sampled its trailer. The packet is still passed through.
- R8: While a packet is being received, start detection is suppressed, so `101` patterns inside a payload do not start a packet. A new start pattern may begin at the very next bit after a trailer.
- R9: During the high phase, `cmd_out` shows the bit of `cmd_in` sampled at the rising edge that began that phase. During the low phase, it shows the bit sampled at the falling edge that began that phase.
- R10: A reset that arrives in the middle of an outgoing request cuts the output off at once, and a reset in the middle of an incoming request discards it. A complete request received after the reset is forwarded normally.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 40 MHz bunch clock; both edges are used |
| rst | input | 1 | Synchronous active-high reset |
| own_pos | input | 14 | This hybrid's position address |
| req_in | input | 1 | Dual-edge request line: regional requests on rising edges, trigger readouts on falling edges |
| cmd_in | input | 1 | Dual-edge line: command on rising edges, trigger on falling edges |
| req_out | output | 1 | Merged output: shortened requests while clk is high, delayed trigger readouts while clk is low |
| cmd_out | output | 1 | Regenerated command/trigger line |
| trailer_err | output | 1 | Sticky flag for a packet received with a bad trailer |

## Verification
The hardest situation to reach is a payload that contains the start pattern, followed at once by a second request that begins on the bit after the first trailer. A receiver that kept hunting inside the payload, or that missed the re-arm point, would misframe both requests. The bench sends two requests back to back, each with `101` sequences embedded in its position and identifier fields. It then checks that both shortened packets come out intact and that no trailer error appears. A reset placed inside an outgoing packet and another inside an incoming one are handled the same way. The bench drives each from a per-cycle stimulus table and checks every half cycle of the output.

// File: rtl/ddrf_pkg.sv
package ddrf_pkg;
  localparam int            START_W   = 3;
  localparam logic [2:0]    START_PAT = 3'b101;

  typedef enum logic { RX_HUNT = 1'b0, RX_BODY = 1'b1 } rx_state_t;
endpackage

// File: rtl/edge_pkt_rx.sv
module edge_pkt_rx
  import ddrf_pkg::*;
#(
  parameter int PAY_W = 23
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             din,
  output logic             done,
  output logic [PAY_W-1:0] pay,
  output logic             busy
);
  localparam int CW = $clog2(PAY_W);

  rx_state_t      st;
  logic [1:0]     hist;
  logic [CW-1:0]  cnt;
  logic           start_seen;

  assign start_seen = (st == RX_HUNT) && ({hist, din} == START_PAT);
  assign busy       = (st == RX_BODY);

  always_ff @(posedge clk) begin
    if (rst) begin
      st   <= RX_HUNT;
      hist <= '0;
      cnt  <= '0;
      pay  <= '0;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        RX_HUNT: begin
          if (start_seen) begin
            st   <= RX_BODY;
            hist <= '0;
            cnt  <= '0;
          end else begin
            hist <= {hist[0], din};
          end
        end
        default: begin
          pay <= {pay[PAY_W-2:0], din};
          if (cnt == CW'(PAY_W - 1)) begin
            st   <= RX_HUNT;
            done <= 1'b1;
            cnt  <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
      endcase
    end
  end

  // R8
  done_after_body_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(busy));

  // R8
  done_single_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R8
  body_exit_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && !$past(busy)) |=> (busy || done));
endmodule

// File: rtl/r3s_ser.sv
module r3s_ser #(
  parameter int LEN = 12
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           load,
  input  logic [LEN-1:0] pkt,
  output logic           bit_o,
  output logic           active
);
  localparam int LW = $clog2(LEN);

  logic [LEN-2:0] sh;
  logic [LW-1:0]  left;

  assign active = (left != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      sh    <= '0;
      left  <= '0;
      bit_o <= 1'b0;
    end else if (load) begin
      bit_o <= pkt[LEN-1];
      sh    <= pkt[LEN-2:0];
      left  <= LW'(LEN - 1);
    end else if (active) begin
      bit_o <= sh[LEN-2];
      sh    <= {sh[LEN-3:0], 1'b0};
      left  <= left - 1'b1;
    end else begin
      bit_o <= 1'b0;
    end
  end

  // R2
  load_idle_chk: assert property (@(posedge clk) disable iff (rst)
    load |-> !active);

  // R2
  first_bit_chk: assert property (@(posedge clk) disable iff (rst)
    load |=> (bit_o == $past(pkt[LEN-1])));
endmodule

// File: rtl/dual_edge_req_filter.sv
module dual_edge_req_filter
  import ddrf_pkg::*;
#(
  parameter int POS_W = 14,
  parameter int ID_W  = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [POS_W-1:0] own_pos,
  input  logic             req_in,
  input  logic             cmd_in,
  output logic             req_out,
  output logic             cmd_out,
  output logic             trailer_err
);
  localparam int R3_PAY = POS_W + ID_W + 1;
  localparam int L1_PAY = ID_W + 1;
  localparam int R3S_W  = START_W + ID_W + 1;

  function automatic logic pos_hit(input logic [POS_W-1:0] pos,
                                   input logic [POS_W-1:0] own);
    return (pos == own) || (&pos);
  endfunction

  function automatic logic [R3S_W-1:0] r3s_pack(input logic [ID_W-1:0] id);
    return {START_PAT, id, 1'b1};
  endfunction

  logic clk_n;
  assign clk_n = ~clk;

  // rising-edge request lane
  logic              r3_done, r3_busy;
  logic [R3_PAY-1:0] r3_pay;
  logic [POS_W-1:0]  r3_pos;
  logic [ID_W-1:0]   r3_id;
  logic              r3_trl, r3_hit, r3_fwd, r3_bad;

  edge_pkt_rx #(.PAY_W(R3_PAY)) u_rx_rise (
    .clk(clk), .rst(rst), .din(req_in),
    .done(r3_done), .pay(r3_pay), .busy(r3_busy)
  );

  assign r3_pos = r3_pay[R3_PAY-1 -: POS_W];
  assign r3_id  = r3_pay[ID_W:1];
  assign r3_trl = r3_pay[0];
  assign r3_hit = pos_hit(r3_pos, own_pos);
  assign r3_fwd = r3_done && r3_trl && r3_hit;
  assign r3_bad = r3_done && !r3_trl;

  logic ser_bit, ser_active;

  r3s_ser #(.LEN(R3S_W)) u_ser (
    .clk(clk), .rst(rst), .load(r3_fwd), .pkt(r3s_pack(r3_id)),
    .bit_o(ser_bit), .active(ser_active)
  );

  // falling-edge trigger readout lane
  logic              l1_done, l1_busy, l1_bad;
  logic [L1_PAY-1:0] l1_pay;

  edge_pkt_rx #(.PAY_W(L1_PAY)) u_rx_fall (
    .clk(clk_n), .rst(rst), .din(req_in),
    .done(l1_done), .pay(l1_pay), .busy(l1_busy)
  );

  assign l1_bad = l1_done && !l1_pay[0];

  logic            fall_d1, fall_q, trg_q, cmd_q;
  logic [ID_W-1:0] fall_hist;

  always_ff @(negedge clk) begin
    if (rst) begin
      fall_d1   <= 1'b0;
      fall_q    <= 1'b0;
      trg_q     <= 1'b0;
      fall_hist <= '0;
    end else begin
      fall_d1   <= req_in;
      fall_q    <= fall_d1;
      trg_q     <= cmd_in;
      fall_hist <= {fall_hist[ID_W-2:0], fall_d1};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_q       <= 1'b0;
      trailer_err <= 1'b0;
    end else begin
      cmd_q       <= cmd_in;
      trailer_err <= trailer_err | r3_bad | l1_bad;
    end
  end

  assign req_out = clk ? ser_bit : fall_q;
  assign cmd_out = clk ? cmd_q   : trg_q;

  // R3
  miss_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (r3_done && !r3_hit && !ser_active) |=> !ser_active);

  // R5
  bad_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (r3_bad && !ser_active) |=> !ser_active);

  // R5
  err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    trailer_err |=> trailer_err);

  // R7
  l1_err_chk: assert property (@(posedge clk) disable iff (rst)
    l1_bad |=> trailer_err);

  // R6
  l1_echo_chk: assert property (@(negedge clk) disable iff (rst)
    l1_done |-> (fall_hist == l1_pay[ID_W:1]));

  // R8
  lanes_busy_chk: assert property (@(posedge clk) disable iff (rst)
    r3_fwd |-> !r3_busy);
endmodule

// File: tb/sim_dual_edge_req_filter.sv
module sim_dual_edge_req_filter;
  localparam int N = 110;

  logic clk, rst, req_in, cmd_in;
  logic [13:0] own_pos;
  logic req_out, cmd_out, trailer_err;

  int checks = 0;
  int fails  = 0;

  bit   rb[N], fb[N], cb[N], tb[N], rs[N], ehi[N], eerr[N];
  logic hi[N], lo[N], chi[N], clo[N], eh[N];

  dual_edge_req_filter u0 (
    .clk(clk), .rst(rst), .own_pos(own_pos), .req_in(req_in),
    .cmd_in(cmd_in), .req_out(req_out), .cmd_out(cmd_out),
    .trailer_err(trailer_err)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input string tag, input int n, input logic act, input bit exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s cycle %0d: actual %b expected %b", tag, n, act, exp);
    end
  endtask

  task automatic clear_all();
    for (int i = 0; i < N; i++) begin
      rb[i] = 0; fb[i] = 0; cb[i] = 0; tb[i] = 0;
      rs[i] = (i < 3); ehi[i] = 0; eerr[i] = 0;
    end
  endtask

  task automatic put_r3(input int s, input bit [13:0] pos, input bit [7:0] id, input bit trl);
    bit [25:0] p;
    p = {3'b101, pos, id, trl};
    for (int i = 0; i < 26; i++) rb[s+i] = p[25-i];
  endtask

  task automatic exp_r3s(input int s, input bit [7:0] id);
    bit [11:0] q;
    q = {3'b101, id, 1'b1};
    for (int j = 0; j < 12; j++) ehi[s+26+j] = q[11-j];
  endtask

  task automatic put_l1(input int t, input bit [7:0] id, input bit trl);
    bit [11:0] p;
    p = {3'b101, id, trl};
    for (int i = 0; i < 12; i++) fb[t+i] = p[11-i];
  endtask

  task automatic err_from(input int a, input int b);
    for (int k = a; k < b; k++) eerr[k] = 1;
  endtask

  task automatic run_cmp(input string rh, input string re);
    bit elo;
    @(negedge clk); #2;
    for (int n = 0; n < N; n++) begin
      rst = rs[n]; req_in = rb[n]; cmd_in = cb[n];
      @(posedge clk); #1;
      req_in = fb[n]; cmd_in = tb[n];
      #1;
      hi[n] = req_out; chi[n] = cmd_out; eh[n] = trailer_err;
      @(negedge clk); #2;
      lo[n] = req_out; clo[n] = cmd_out;
    end
    rst = 0; req_in = 0; cmd_in = 0;
    for (int n = 0; n < N; n++) begin
      chk(rh, n, hi[n], ehi[n]);
      if (n == 0) elo = 0;
      else elo = (rs[n] || rs[n-1]) ? 1'b0 : fb[n-1];
      chk("R6 low phase", n, lo[n], elo);
      chk("R9 cmd high", n, chi[n], rs[n] ? 1'b0 : cb[n]);
      chk("R9 cmd low", n, clo[n], rs[n] ? 1'b0 : tb[n]);
      chk(re, n, eh[n], eerr[n]);
    end
  endtask

  // R1: activity during reset, nothing afterwards
  task automatic t_reset();
    clear_all();
    own_pos = 14'h0000;
    rs[3] = 1;
    rb[0] = 1; rb[1] = 0; rb[2] = 1; rb[3] = 1;
    fb[0] = 1; fb[1] = 0; fb[2] = 1; fb[3] = 1;
    run_cmp("R1 reset high", "R1 reset err");
  endtask

  // R2 R8: back-to-back matching requests with 101 inside payloads
  task automatic t_match();
    clear_all();
    own_pos = 14'h2D6A;
    put_r3(4, 14'h2D6A, 8'hA5, 1'b1);  exp_r3s(4, 8'hA5);
    put_r3(30, 14'h2D6A, 8'h5A, 1'b1); exp_r3s(30, 8'h5A);
    run_cmp("R2 R8 forward", "R8 no false frame err");
  endtask

  // R3 R4: mismatching positions and broadcast
  task automatic t_addr();
    clear_all();
    own_pos = 14'h1234;
    put_r3(4, 14'h1235, 8'h11, 1'b1);
    put_r3(32, 14'h3FFF, 8'hC3, 1'b1); exp_r3s(32, 8'hC3);
    put_r3(62, 14'h3234, 8'h22, 1'b1);
    run_cmp("R3 R4 address filter", "R3 err");
  endtask

  // R5: bad trailer dropped, sticky flag, later request still forwarded
  task automatic t_trailer();
    clear_all();
    own_pos = 14'h0F0F;
    put_r3(4, 14'h0F0F, 8'h77, 1'b0);
    put_r3(34, 14'h0F0F, 8'h3B, 1'b1); exp_r3s(34, 8'h3B);
    err_from(30, N);
    run_cmp("R5 drop", "R5 sticky err");
  endtask

  // R6 R7: trigger packets on the falling lane alongside a request
  task automatic t_l1();
    clear_all();
    own_pos = 14'h0155;
    put_r3(4, 14'h0155, 8'h3C, 1'b1); exp_r3s(4, 8'h3C);
    put_l1(3, 8'h96, 1'b1);
    put_l1(20, 8'h69, 1'b0);
    err_from(32, N);
    run_cmp("R6 rise lane", "R7 l1 trailer err");
  endtask

  // R9: command line regeneration
  task automatic t_cmd();
    clear_all();
    own_pos = 14'h0001;
    for (int n = 3; n < N; n++) begin
      cb[n] = (n % 3 == 0);
      tb[n] = (n % 2 == 1);
    end
    run_cmp("R9 rise idle", "R9 err");
  endtask

  // R10: reset inside an outgoing and an incoming request
  task automatic t_midreset();
    clear_all();
    own_pos = 14'h2AAA;
    put_r3(4, 14'h2AAA, 8'h81, 1'b1); exp_r3s(4, 8'h81);
    rs[33] = 1;
    for (int k = 33; k < 42; k++) ehi[k] = 0;
    put_l1(4, 8'h0F, 1'b0);
    err_from(16, 33);
    put_r3(45, 14'h2AAA, 8'h42, 1'b1);
    for (int k = 55; k < 71; k++) rb[k] = 0;
    rs[52] = 1;
    put_r3(60, 14'h2AAA, 8'hE7, 1'b1); exp_r3s(60, 8'hE7);
    run_cmp("R10 mid reset", "R10 err cleared");
  endtask

  initial begin
    rst = 1; req_in = 0; cmd_in = 0; own_pos = '0;
    t_reset();
    t_match();
    t_addr();
    t_trailer();
    t_l1();
    t_cmd();
    t_midreset();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #1_500_000;
    fails++;
    $display("FAIL watchdog (all requirements): actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule